// File: doc/BRIEF.md
# Sized Integer ALU with Masked Condition Flags

This block is the integer arithmetic and logic stage of a micro-op execution engine. Each cycle it takes two 64-bit source values, an operation code, an operand-width code and a flag-update mask. It also takes the current destination register value and the current condition-flag word. It returns a new destination value and a new flag word one clock later. The supported operations are add, add-with-carry, subtract, subtract-with-borrow, AND, OR and XOR. The second operand comes either from a register value or from a sign-extended 8-bit immediate, and both paths feed the same datapath.

Results narrower than the register are merged into the old destination value. Which part is preserved depends on the width code. The flag word holds six condition bits. Only the bits selected by the mask may change; every other bit keeps its incoming value. Subtraction reuses the adder with the second operand inverted, so carry, borrow and overflow all come from one carry chain. The logic operations never produce carry, overflow or adjust information, so those bits are forced to zero when the mask selects them.

The block has no sequencing of its own. There is no state machine: a single register stage captures the merged destination and the flag word on every rising clock edge.

Top module: `sized_alu`

## Requirements
- R1: Outputs are registered. Values presented before a rising edge of `clk` appear on `dest_out`/`flags_out` after that edge. While `rst_n` is low, both outputs are zero.
- R2: `op_sel` encodings: 0 add, 1 add plus incoming CF, 2 subtract, 3 subtract minus incoming CF, 4 AND, 5 OR, 6 XOR, and 7 behaves as plain add. The incoming CF is `flags_old` bit 0.
- R3: `size_sel` encodings: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. For 8 and 16 bits, the destination bits above the width keep `dest_old`. For 32 bits, bits 63:32 become zero. For 64 bits, the whole result is written.
- R4: When `use_imm` is 1, the second operand is `imm8` sign-extended to 64 bits and `src_b` is ignored. When `use_imm` is 0, the second operand is `src_b`.
- R5: Flag word layout: bit 0 CF, bit 1 PF, bit 2 AF, bit 3 ZF, bit 4 SF, bit 5 OF. A flag bit whose `flag_mask` bit is 0 equals the corresponding `flags_old` bit.
- R6: For arithmetic ops, CF is the carry out of the top bit of the selected width; for subtracts it is the borrow. OF is signed overflow at that width.
- R7: ZF is 1 when the sized result is zero. SF is the top bit of the sized result. PF is 1 when the low 8 result bits hold an even number of ones.
- R8: For arithmetic ops, AF is the carry (for subtracts, the borrow) out of bit 3.
- R9: For AND, OR and XOR, the selected CF, OF and AF bits become 0, while ZF, SF and PF follow R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 3 | Operation code (R2) |
| size_sel | input | 2 | Operand width code (R3) |
| use_imm | input | 1 | Select immediate as second operand |
| imm8 | input | 8 | Immediate second operand |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Register second operand |
| dest_old | input | 64 | Current destination register value |
| flags_old | input | 6 | Current condition-flag word |
| flag_mask | input | 6 | Flags permitted to change |
| dest_out | output | 64 | Registered merged destination |
| flags_out | output | 6 | Registered updated flag word |

## Verification
Several relations are checked by assertions on every cycle, between the merge stage, the flag stage and the block's inputs:
- unmasked flag bits keep their incoming values;
- logic ops clear a selected CF, OF or AF;
- narrow widths keep the upper destination bits, and the 32-bit width clears them;
- a selected ZF agrees with the merged sized destination.

The actual arithmetic values are shown only by the bench's scenarios, against a reference computed with wide signed and unsigned integers. These values are carry and borrow at each width, signed overflow, the bit-3 adjust carry, parity, the chained use of the incoming CF, and immediate sign extension.

// File: rtl/sized_alu_pkg.sv
package sized_alu_pkg;

    localparam int ALU_W  = 64;
    localparam int FLAG_W = 6;
    localparam int IMM_W  = 8;

    localparam int F_CF = 0;
    localparam int F_PF = 1;
    localparam int F_AF = 2;
    localparam int F_ZF = 3;
    localparam int F_SF = 4;
    localparam int F_OF = 5;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBB = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_RSV  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } alu_size_e;

    function automatic logic [ALU_W-1:0] width_mask(alu_size_e sz);
        logic [ALU_W-1:0] m;
        unique case (sz)
            SZ_8:    m = {{(ALU_W-8){1'b0}},  {8{1'b1}}};
            SZ_16:   m = {{(ALU_W-16){1'b0}}, {16{1'b1}}};
            SZ_32:   m = {{(ALU_W-32){1'b0}}, {32{1'b1}}};
            default: m = {ALU_W{1'b1}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import sized_alu_pkg::*;
#(
    parameter int W   = ALU_W,
    parameter int IW  = IMM_W
) (
    input  logic          use_imm,
    input  logic [IW-1:0] imm,
    input  logic [W-1:0]  reg_val,
    output logic [W-1:0]  operand
);
    localparam int EXT_W = W - IW;

    always_comb begin
        if (use_imm) begin
            operand = {{EXT_W{imm[IW-1]}}, imm};
        end else begin
            operand = reg_val;
        end
    end
endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain
    import sized_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         invert_rhs,
    input  logic         carry_in,
    input  alu_size_e    size,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         carry_into_msb,
    output logic         nibble_carry
);
    logic [W-1:0] msk;
    logic [W-1:0] lhs_m;
    logic [W-1:0] rhs_e;
    logic [W:0]   total;

    always_comb begin
        msk   = width_mask(size);
        lhs_m = lhs & msk;
        rhs_e = (invert_rhs ? ~rhs : rhs) & msk;
        total = {1'b0, lhs_m} + {1'b0, rhs_e} + {{W{1'b0}}, carry_in};
        sum   = total[W-1:0];
        unique case (size)
            SZ_8: begin
                carry_out      = total[8];
                carry_into_msb = lhs_m[7] ^ rhs_e[7] ^ total[7];
            end
            SZ_16: begin
                carry_out      = total[16];
                carry_into_msb = lhs_m[15] ^ rhs_e[15] ^ total[15];
            end
            SZ_32: begin
                carry_out      = total[32];
                carry_into_msb = lhs_m[31] ^ rhs_e[31] ^ total[31];
            end
            default: begin
                carry_out      = total[W];
                carry_into_msb = lhs_m[W-1] ^ rhs_e[W-1] ^ total[W-1];
            end
        endcase
        // carry (add) or borrow (subtract) into bit 4
        nibble_carry = lhs[4] ^ rhs[4] ^ total[4];
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import sized_alu_pkg::*;
#(
    parameter int W  = ALU_W,
    parameter int FW = FLAG_W
) (
    input  logic [W-1:0]  result,
    input  alu_size_e     size,
    input  logic          is_logic,
    input  logic          is_sub,
    input  logic          carry_out,
    input  logic          carry_into_msb,
    input  logic          nibble_carry,
    input  logic [FW-1:0] flags_old,
    input  logic [FW-1:0] mask,
    output logic [FW-1:0] flags_new
);
    logic [FW-1:0] calc;
    logic          top_bit;

    always_comb begin
        unique case (size)
            SZ_8:    top_bit = result[7];
            SZ_16:   top_bit = result[15];
            SZ_32:   top_bit = result[31];
            default: top_bit = result[W-1];
        endcase
        calc       = '0;
        calc[F_ZF] = ((result & width_mask(size)) == '0);
        calc[F_SF] = top_bit;
        calc[F_PF] = ~(^result[7:0]);
        if (!is_logic) begin
            calc[F_CF] = is_sub ? ~carry_out : carry_out;
            calc[F_OF] = carry_into_msb ^ carry_out;
            calc[F_AF] = nibble_carry;
        end
        flags_new = (flags_old & ~mask) | (calc & mask);
    end
endmodule

// File: rtl/alu_size_merge.sv
module alu_size_merge
    import sized_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0] result,
    input  logic [W-1:0] old_val,
    input  alu_size_e    size,
    output logic [W-1:0] merged
);
    logic [W-1:0] msk;

    always_comb begin
        msk = width_mask(size);
        unique case (size)
            SZ_8, SZ_16: merged = (old_val & ~msk) | (result & msk);
            SZ_32:       merged = result & msk;
            default:     merged = result;
        endcase
    end
endmodule

// File: rtl/sized_alu.sv
module sized_alu
    import sized_alu_pkg::*;
#(
    parameter int W  = ALU_W,
    parameter int FW = FLAG_W,
    parameter int IW = IMM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_sel,
    input  logic [1:0]    size_sel,
    input  logic          use_imm,
    input  logic [IW-1:0] imm8,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic [W-1:0]  dest_old,
    input  logic [FW-1:0] flags_old,
    input  logic [FW-1:0] flag_mask,
    output logic [W-1:0]  dest_out,
    output logic [FW-1:0] flags_out
);
    alu_op_e      op;
    alu_size_e    size;
    logic [W-1:0] op2;
    logic [W-1:0] arith_sum;
    logic [W-1:0] raw_result;
    logic [W-1:0] dest_nxt;
    logic [FW-1:0] flags_nxt;
    logic         is_logic;
    logic         is_sub;
    logic         cin;
    logic         c_out;
    logic         c_msb;
    logic         c_nib;

    assign op   = alu_op_e'(op_sel);
    assign size = alu_size_e'(size_sel);

    alu_operand_sel #(.W(W), .IW(IW)) u_opnd (
        .use_imm (use_imm),
        .imm     (imm8),
        .reg_val (src_b),
        .operand (op2)
    );

    always_comb begin
        is_logic = 1'b0;
        is_sub   = 1'b0;
        cin      = 1'b0;
        unique case (op)
            OP_ADDC: cin = flags_old[F_CF];
            OP_SUB: begin
                is_sub = 1'b1;
                cin    = 1'b1;
            end
            OP_SUBB: begin
                is_sub = 1'b1;
                cin    = ~flags_old[F_CF];
            end
            OP_AND, OP_OR, OP_XOR: is_logic = 1'b1;
            default: cin = 1'b0;
        endcase
    end

    alu_carry_chain #(.W(W)) u_chain (
        .lhs            (src_a),
        .rhs            (op2),
        .invert_rhs     (is_sub),
        .carry_in       (cin),
        .size           (size),
        .sum            (arith_sum),
        .carry_out      (c_out),
        .carry_into_msb (c_msb),
        .nibble_carry   (c_nib)
    );

    always_comb begin
        unique case (op)
            OP_AND:  raw_result = src_a & op2;
            OP_OR:   raw_result = src_a | op2;
            OP_XOR:  raw_result = src_a ^ op2;
            default: raw_result = arith_sum;
        endcase
    end

    alu_flag_gen #(.W(W), .FW(FW)) u_flags (
        .result         (raw_result),
        .size           (size),
        .is_logic       (is_logic),
        .is_sub         (is_sub),
        .carry_out      (c_out),
        .carry_into_msb (c_msb),
        .nibble_carry   (c_nib),
        .flags_old      (flags_old),
        .mask           (flag_mask),
        .flags_new      (flags_nxt)
    );

    alu_size_merge #(.W(W)) u_merge (
        .result  (raw_result),
        .old_val (dest_old),
        .size    (size),
        .merged  (dest_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_out  <= '0;
            flags_out <= '0;
        end else begin
            dest_out  <= dest_nxt;
            flags_out <= flags_nxt;
        end
    end

    // R5: bits outside the mask follow the incoming flag word
    a_r5_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_nxt & ~flag_mask) == (flags_old & ~flag_mask));

    // R9: logic ops clear selected CF and OF
    a_r9_logic_cf_of_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic && (flag_mask[F_CF] || flag_mask[F_OF])) |->
        !((flag_mask[F_CF] && flags_nxt[F_CF]) || (flag_mask[F_OF] && flags_nxt[F_OF])));

    // R9: logic ops clear a selected AF
    a_r9_logic_af_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic && flag_mask[F_AF]) |-> !flags_nxt[F_AF]);

    // R3: narrow widths keep the upper destination bits
    a_r3_narrow_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_8 || size == SZ_16) |->
        (dest_nxt[W-1:16] == dest_old[W-1:16]));

    // R3: 32-bit width clears the upper half
    a_r3_dword_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_32) |-> (dest_nxt[W-1:32] == '0));

    // R7: a selected ZF matches the merged sized destination
    a_r7_zf_matches_dest: assert property (@(posedge clk) disable iff (!rst_n)
        flag_mask[F_ZF] |-> (flags_nxt[F_ZF] == ((dest_nxt & width_mask(size)) == '0)));

    // R1: reset holds the outputs at zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (dest_out == '0 && flags_out == '0));
endmodule

// File: tb/tb_sized_alu.sv
module tb_sized_alu;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic        use_imm = 1'b0;
    logic [7:0]  imm8 = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] dest_old = '0;
    logic [5:0]  flags_old = '0;
    logic [5:0]  flag_mask = '0;
    logic [63:0] dest_out;
    logic [5:0]  flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sized_alu dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .size_sel(size_sel),
        .use_imm(use_imm), .imm8(imm8), .src_a(src_a), .src_b(src_b),
        .dest_old(dest_old), .flags_old(flags_old), .flag_mask(flag_mask),
        .dest_out(dest_out), .flags_out(flags_out)
    );

    function automatic logic signed [65:0] sext_n(logic [63:0] v, int n);
        logic signed [65:0] t;
        t = $signed({2'b00, v});
        if (v[n-1]) t = t - (66'sd1 <<< n);
        return t;
    endfunction

    task automatic model(output logic [63:0] exp_d, output logic [5:0] exp_f);
        int n;
        logic [63:0] m, b, am, bm, r;
        logic [65:0] u;
        logic signed [65:0] sr, lim;
        logic c, cf, of, af;
        logic [5:0] calc;
        n  = 8 << size_sel;
        m  = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
        b  = use_imm ? {{56{imm8[7]}}, imm8} : src_b;
        am = src_a & m;
        bm = b & m;
        lim = 66'sd1 <<< (n - 1);
        cf = 0; of = 0; af = 0;
        case (op_sel)
            3'd2, 3'd3: begin
                c  = (op_sel == 3'd3) ? flags_old[0] : 1'b0;
                u  = {2'b00, am} - {2'b00, bm} - {65'd0, c};
                r  = u[63:0] & m;
                cf = u[65];
                sr = sext_n(am, n) - sext_n(bm, n) - $signed({65'd0, c});
                of = (sr >= lim) || (sr < -lim);
                af = ({1'b0, am[3:0]}) < ({1'b0, bm[3:0]} + {4'd0, c});
            end
            3'd4: r = (src_a & b) & m;
            3'd5: r = (src_a | b) & m;
            3'd6: r = (src_a ^ b) & m;
            default: begin
                c  = (op_sel == 3'd1) ? flags_old[0] : 1'b0;
                u  = {2'b00, am} + {2'b00, bm} + {65'd0, c};
                r  = u[63:0] & m;
                cf = (u >> n) != 0;
                sr = sext_n(am, n) + sext_n(bm, n) + $signed({65'd0, c});
                of = (sr >= lim) || (sr < -lim);
                af = ({1'b0, am[3:0]} + {1'b0, bm[3:0]} + {4'd0, c}) > 5'd15;
            end
        endcase
        calc = {of, r[n-1], (r == 64'd0), af, ~(^r[7:0]), cf};
        exp_f = (flags_old & ~flag_mask) | (calc & flag_mask);
        exp_d = (n < 32) ? ((dest_old & ~m) | r) : r;
    endtask

    task automatic check_d(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s dest op=%0d sz=%0d act=%h exp=%h", tag, op_sel, size_sel, act, exp);
        end
    endtask

    task automatic check_f(string tag, logic [5:0] act, logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s flags op=%0d sz=%0d act=%b exp=%b", tag, op_sel, size_sel, act, exp);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge (one register)
    task automatic run(string tag, logic [2:0] op, logic [1:0] sz, logic ui, logic [7:0] im,
                       logic [63:0] a, logic [63:0] bb, logic [63:0] dold,
                       logic [5:0] fold, logic [5:0] fm);
        logic [63:0] ed;
        logic [5:0]  ef;
        logic [63:0] prev_d;
        logic [5:0]  prev_f;
        @(negedge clk);
        prev_d = dest_out;
        prev_f = flags_out;
        op_sel = op; size_sel = sz; use_imm = ui; imm8 = im;
        src_a = a; src_b = bb; dest_old = dold; flags_old = fold; flag_mask = fm;
        model(ed, ef);
        #(CLK_PERIOD/4);
        check_d("R1 hold", dest_out, prev_d);
        @(negedge clk);
        check_d(tag, dest_out, ed);
        check_f(tag, flags_out, ef);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A11_0C0D));
        repeat (3) @(negedge clk);
        check_d("R1 reset", dest_out, 64'd0);
        check_f("R1 reset", flags_out, 6'd0);
        rst_n = 1'b1;

        // R6 R8 R7: byte carry out, zero result, adjust carry
        run("R6 R8 R7 byte wrap", 3'd0, 2'd0, 0, 0, 64'hFF, 64'h01, 64'hAAAA_BBBB_CCCC_DDDD, 6'h00, 6'h3F);
        // R6: byte signed overflow
        run("R6 byte ovf", 3'd0, 2'd0, 0, 0, 64'h7F, 64'h01, 64'h0, 6'h00, 6'h3F);
        // R6 R8: subtract borrow at 16 bits, upper kept (R3)
        run("R6 R3 word borrow", 3'd2, 2'd1, 0, 0, 64'h0, 64'h1, 64'h1234_5678_9ABC_DEF0, 6'h00, 6'h3F);
        // R2: add with incoming carry
        run("R2 adc", 3'd1, 2'd2, 0, 0, 64'hFFFF_FFFF, 64'h0, 64'hFFFF_FFFF_0000_0000, 6'h01, 6'h3F);
        // R2: subtract with incoming borrow
        run("R2 sbb", 3'd3, 2'd3, 0, 0, 64'h5, 64'h5, 64'h0, 6'h01, 6'h3F);
        // R6: 64-bit signed overflow
        run("R6 qword ovf", 3'd0, 2'd3, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 6'h00, 6'h3F);
        // R3: 32-bit clears upper half
        run("R3 dword zero", 3'd5, 2'd2, 0, 0, 64'h1, 64'h2, 64'hFFFF_FFFF_FFFF_FFFF, 6'h00, 6'h3F);
        // R9: logic op with all flags selected and CF/OF/AF set in old word
        run("R9 logic clear", 3'd4, 2'd3, 0, 0, 64'hF0F0, 64'h0FF0, 64'h0, 6'h3F, 6'h3F);
        // R5: empty mask keeps every old flag
        run("R5 mask none", 3'd0, 2'd0, 0, 0, 64'hFF, 64'h01, 64'h0, 6'h2A, 6'h00);
        // R4: negative immediate is sign-extended, src_b ignored
        run("R4 imm neg", 3'd0, 2'd3, 1, 8'hFF, 64'h10, 64'hDEAD_BEEF, 64'h0, 6'h00, 6'h3F);
        run("R4 imm pos", 3'd2, 2'd1, 1, 8'h7F, 64'h80, 64'hFFFF, 64'hCAFE_0000_0000_0000, 6'h00, 6'h3F);
        // R2: reserved code behaves as add; R7 parity on XOR
        run("R2 rsv add", 3'd7, 2'd0, 0, 0, 64'h0F, 64'h01, 64'h0, 6'h00, 6'h3F);
        run("R7 parity xor", 3'd6, 2'd0, 0, 0, 64'h03, 64'h00, 64'h0, 6'h00, 6'h3F);

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (($urandom % 4) == 0) ra = ra & 64'hFF;
            if (($urandom % 4) == 0) rb = ~ra;
            run("R2 R3 R4 R5 R6 R7 R8 R9 random", 3'($urandom % 8), 2'($urandom % 4),
                1'($urandom % 2), 8'($urandom), ra, rb, {$urandom, $urandom},
                6'($urandom), 6'($urandom));
        end

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_d("R1 reset again", dest_out, 64'd0);
        check_f("R1 reset again", flags_out, 6'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule